// File: doc/BRIEF.md
# Integer ALU with Condition-Flag Register

This block is a 32-bit integer arithmetic and logic unit that keeps its own condition-flag word for branch logic. A pulse on `start` captures two operands, a 4-bit opcode and an 8-bit shift count. One cycle later the unit produces a result and a one-cycle destination write-enable. It also updates the flag word, which stays visible on `flags` until the next operation that changes it. The supported operations are add, subtract, increment, decrement, the bitwise and/or/xor/not, negate, logical shift left and right, and compare. Compare subtracts only to set the flags and never requests a register write.

Control is a two-state machine. In `ST_IDLE` the unit waits for `start`; the transition GO latches the inputs and moves to `ST_EXEC`. In `ST_EXEC` the latched operation is evaluated, and the outputs and flags are registered on the closing edge. The unconditional transition RETIRE then returns to `ST_IDLE`. A `start` seen while in `ST_EXEC` is ignored. A new operation may therefore be issued every second cycle.

Opcode encoding: add 0, sub 1, inc 2, dec 3, and 4, or 5, xor 6, not 7, neg 8, shl 9, shr 10, cmp 11. Codes 12 to 15 are undefined. Flag positions: bit 0 carry/borrow, bit 6 zero, bit 7 sign.

Top module: `alu_flags_unit`

## Requirements
- R1: A `start` sampled in ST_IDLE makes `dst_we` and `result` valid after the next rising edge. `dst_we` is high for exactly one cycle. A `start` sampled in ST_EXEC is ignored.
- R2: add (0) returns a+b, sub (1) returns a-b, inc (2) returns a+1 and dec (3) returns a-1, all modulo 2^32, with `dst_we` high.
- R3: and (4), or (5) and xor (6) combine a with b bitwise, and not (7) inverts every bit of a, with `dst_we` high.
- R4: neg (8) returns the two's-complement negation of a and sets the carry bit when a is nonzero.
- R5: shl (9) and shr (10) shift a by the low 5 bits of the shift count (the count modulo 32) and fill the vacated positions with zeros.
- R6: A shift whose effective count is zero returns a unchanged with `dst_we` high and leaves every flag bit unchanged.
- R7: cmp (11) sets the flags exactly as sub would, keeps `dst_we` low and leaves `result` at its previous value.
- R8: Every flag-updating operation sets bit 6 when its result is zero and copies bit 31 of its result into bit 7.
- R9: Bit 0 takes the carry out of add and the unsigned borrow (a<b) of sub and cmp. inc and dec keep it. and, or, xor, not, shl and shr clear it.
- R10: After reset `flags`, `result` and `dst_we` are zero. Flag bits other than 0, 6 and 7 always read zero.
- R11: Opcodes 12 to 15 keep `dst_we` low and leave `result` and `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted in ST_IDLE only) |
| opcode | input | 4 | Operation code |
| src_a | input | 32 | First operand (destination value) |
| src_b | input | 32 | Second operand |
| shamt | input | 8 | Shift count, used modulo 32 |
| result | output | 32 | Registered result of the last writing operation |
| dst_we | output | 1 | One-cycle destination write-enable |
| flags | output | 32 | Condition-flag word |

## Verification
The bench targets several corner cases, and each exposes a specific kind of bug:
- Carry out of an add that wraps to zero: a design that dropped bit 32 would report no carry, and a design with a mis-wired zero flag would miss the zero.
- Subtract and compare with a < b and with a == b: a design that reversed the operands or treated compare as a write would assert `dst_we` or get the borrow wrong.
- Shift counts of 33 and 32: a design that did not reduce the count modulo 32 would shift out every bit instead of shifting by one or leaving the value alone.
- A zero-count shift made right after a carry-setting add: this shows whether the flags are truly kept.
- Increment after a carry: this shows that the carry survives.
- A `start` held across the execute cycle and an undefined opcode: both must produce no extra write.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_NEG = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_CMP = 4'd11
    } opcode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        CY_KEEP  = 2'd0,
        CY_LOAD  = 2'd1,
        CY_CLEAR = 2'd2
    } carry_mode_e;

    localparam int CF_BIT = 0;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;

endpackage

// File: rtl/alu_compute.sv
module alu_compute
    import alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 8
) (
    input  opcode_e             op,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [SHAMT_W-1:0]  cnt,
    output logic [DATA_W-1:0]   res,
    output logic                wr,
    output logic                upd,
    output carry_mode_e         cy_mode,
    output logic                cy_val
);

    localparam logic [SHAMT_W-1:0] CNT_MASK = SHAMT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0]  ONE      = DATA_W'(1);

    logic [SHAMT_W-1:0] cnt_eff;
    logic [DATA_W:0]    sum_w;
    logic [DATA_W:0]    dif_w;

    assign cnt_eff = cnt & CNT_MASK;
    assign sum_w   = {1'b0, opa} + {1'b0, opb};
    assign dif_w   = {1'b0, opa} - {1'b0, opb};

    always_comb begin
        res     = '0;
        wr      = 1'b1;
        upd     = 1'b1;
        cy_mode = CY_CLEAR;
        cy_val  = 1'b0;
        unique case (op)
            OP_ADD: begin
                res     = sum_w[DATA_W-1:0];
                cy_mode = CY_LOAD;
                cy_val  = sum_w[DATA_W];
            end
            OP_SUB, OP_CMP: begin
                res     = dif_w[DATA_W-1:0];
                cy_mode = CY_LOAD;
                cy_val  = dif_w[DATA_W];
                wr      = (op == OP_SUB);
            end
            OP_INC: begin
                res     = opa + ONE;
                cy_mode = CY_KEEP;
            end
            OP_DEC: begin
                res     = opa - ONE;
                cy_mode = CY_KEEP;
            end
            OP_AND: res = opa & opb;
            OP_OR:  res = opa | opb;
            OP_XOR: res = opa ^ opb;
            OP_NOT: res = ~opa;
            OP_NEG: begin
                res     = '0 - opa;
                cy_mode = CY_LOAD;
                cy_val  = (opa != '0);
            end
            OP_SHL, OP_SHR: begin
                res = (op == OP_SHL) ? (opa << cnt_eff) : (opa >> cnt_eff);
                if (cnt_eff == '0) begin
                    upd = 1'b0;
                end
            end
            default: begin
                wr  = 1'b0;
                upd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               update,
    input  logic [DATA_W-1:0]  res,
    input  carry_mode_e        cy_mode,
    input  logic               cy_val,
    output logic [FLAG_W-1:0]  flag_q
);

    localparam logic [FLAG_W-1:0] LIVE_MASK =
        (FLAG_W'(1) << CF_BIT) | (FLAG_W'(1) << ZF_BIT) | (FLAG_W'(1) << SF_BIT);

    generate
        if (FLAG_W <= SF_BIT) begin : g_bad_width
            initial $error("flag word too narrow for sign bit");
        end
    endgenerate

    logic cy_next;

    always_comb begin
        unique case (cy_mode)
            CY_LOAD:  cy_next = cy_val;
            CY_CLEAR: cy_next = 1'b0;
            default:  cy_next = flag_q[CF_BIT];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (update) begin
            flag_q         <= '0;
            flag_q[CF_BIT] <= cy_next;
            flag_q[ZF_BIT] <= (res == '0);
            flag_q[SF_BIT] <= res[DATA_W-1];
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q & ~LIVE_MASK) == '0);  // R10

    AST_ZF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(update) |-> (flag_q[ZF_BIT] == ($past(res) == '0)));  // R8

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(update) |-> $stable(flag_q));  // R6

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 8,
    parameter int FLAG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          opcode,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [DATA_W-1:0]   result,
    output logic                dst_we,
    output logic [FLAG_W-1:0]   flags
);

    state_e              state_q, state_d;
    opcode_e             op_q;
    logic [DATA_W-1:0]   a_q, b_q;
    logic [SHAMT_W-1:0]  cnt_q;

    logic [DATA_W-1:0]   c_res;
    logic                c_wr, c_upd, c_cy;
    carry_mode_e         c_cy_mode;
    logic                exec;

    assign exec = (state_q == ST_EXEC);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: GO (idle->exec), RETIRE (exec->idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture on GO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_ADD;
            a_q   <= '0;
            b_q   <= '0;
            cnt_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            op_q  <= opcode_e'(opcode);
            a_q   <= src_a;
            b_q   <= src_b;
            cnt_q <= shamt;
        end
    end

    alu_compute #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_compute (
        .op      (op_q),
        .opa     (a_q),
        .opb     (b_q),
        .cnt     (cnt_q),
        .res     (c_res),
        .wr      (c_wr),
        .upd     (c_upd),
        .cy_mode (c_cy_mode),
        .cy_val  (c_cy)
    );

    // outputs, registered on RETIRE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            dst_we <= 1'b0;
        end else begin
            dst_we <= exec && c_wr;
            if (exec && c_wr) result <= c_res;
        end
    end

    alu_status_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .update  (exec && c_upd),
        .res     (c_res),
        .cy_mode (c_cy_mode),
        .cy_val  (c_cy),
        .flag_q  (flags)
    );

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |=> !dst_we);  // R1

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (state_q == ST_IDLE));  // R1

    AST_CMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_q == OP_CMP) |=> (!dst_we && $stable(result)));  // R7

    AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && 4'(op_q) > 4'(OP_CMP)) |=> (!dst_we && $stable(flags) && $stable(result)));  // R11

endmodule

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          due;
        logic [31:0] res;
        logic        we;
        logic [31:0] flg;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [7:0]  shamt = '0;
    logic [31:0] result, flags;
    logic        dst_we;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t sb[$];
    logic [31:0] m_res = '0;
    logic [31:0] m_flg = '0;

    alu_flags_unit u_alu_flags_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .shamt(shamt),
        .result(result), .dst_we(dst_we), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare the outputs against queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res || dst_we !== e.we || flags !== e.flg) begin
                errors++;
                $display("FAIL %s: result=%h we=%b flags=%h expected result=%h we=%b flags=%h",
                         e.tag, result, dst_we, flags, e.res, e.we, e.flg);
            end
        end
    end

    // driver: model the operation, queue the expectation, drive the pins
    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] sh, input bit hold, input string tag);
        logic [32:0] w;
        logic [31:0] r;
        logic        we, upd, cy;
        int          k;
        exp_t        e;
        we = 1'b1; upd = 1'b1; cy = 1'b0; r = '0;
        k = int'(sh) % 32;
        case (op)
            4'd0:  begin w = {1'b0,a} + {1'b0,b}; r = w[31:0]; cy = w[32]; end
            4'd1, 4'd11: begin r = a - b; cy = (a < b); we = (op == 4'd1); end
            4'd2:  begin r = a + 1; cy = m_flg[0]; end
            4'd3:  begin r = a - 1; cy = m_flg[0]; end
            4'd4:  r = a & b;
            4'd5:  r = a | b;
            4'd6:  r = a ^ b;
            4'd7:  r = ~a;
            4'd8:  begin r = -a; cy = (a != 0); end
            4'd9:  begin r = a << k; upd = (k != 0); end
            4'd10: begin r = a >> k; upd = (k != 0); end
            default: begin we = 1'b0; upd = 1'b0; end
        endcase
        if (upd) m_flg = {24'b0, r[31], (r == 0), 5'b0, cy};
        if (we) m_res = r;
        e.due = cyc + 2; e.res = m_res; e.we = we; e.flg = m_flg; e.tag = tag;
        sb.push_back(e);
        if (hold) begin
            e.due = cyc + 3; e.we = 1'b0; e.tag = {tag, " start-held"};
            sb.push_back(e);
        end
        opcode = op; src_a = a; src_b = b; shamt = sh; start = 1'b1;
        @(negedge clk);
        if (hold) @(negedge clk);
        start = 1'b0;
        if (!hold) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;  // R10 reset state
        if (result !== 0 || dst_we !== 0 || flags !== 0) begin
            errors++;
            $display("FAIL R10 reset: result=%h we=%b flags=%h expected 0 0 0", result, dst_we, flags);
        end
        issue(4'd0, 32'h0000_1234, 32'h0000_0010, 8'd0, 0, "R2 add");
        issue(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 8'd0, 0, "R9 add carry to zero R8");
        issue(4'd2, 32'h7FFF_FFFF, 32'h0, 8'd0, 0, "R9 inc keeps carry, sign R8");
        issue(4'd1, 32'h0000_0005, 32'h0000_0009, 8'd0, 0, "R2 sub borrow R9");
        issue(4'd3, 32'h0000_0001, 32'h0, 8'd0, 0, "R2 dec to zero");
        issue(4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 8'd0, 0, "R3 and");
        issue(4'd5, 32'hF000_0000, 32'h0000_000F, 8'd0, 0, "R3 or");
        issue(4'd6, 32'hAAAA_5555, 32'hAAAA_5555, 8'd0, 0, "R3 xor zero");
        issue(4'd7, 32'h0000_FFFF, 32'h0, 8'd0, 0, "R3 not");
        issue(4'd8, 32'h0000_0005, 32'h0, 8'd0, 0, "R4 neg");
        issue(4'd8, 32'h0000_0000, 32'h0, 8'd0, 0, "R4 neg zero");
        issue(4'd9, 32'h8000_0003, 32'h0, 8'd4, 0, "R5 shl");
        issue(4'd9, 32'h4000_0001, 32'h0, 8'd33, 0, "R5 shl count 33");
        issue(4'd10, 32'h8000_0000, 32'h0, 8'd31, 0, "R5 shr");
        issue(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 8'd0, 0, "R9 add carry set");
        issue(4'd10, 32'h1234_5678, 32'h0, 8'd32, 0, "R6 shr count 32");
        issue(4'd9, 32'h0000_0000, 32'h0, 8'd0, 0, "R6 shl count 0");
        issue(4'd11, 32'h0000_000A, 32'h0000_000A, 8'd0, 0, "R7 cmp equal");
        issue(4'd11, 32'h0000_0001, 32'h0000_0002, 8'd0, 0, "R7 cmp less");
        issue(4'd13, 32'hDEAD_BEEF, 32'h1, 8'd0, 0, "R11 undefined op");
        issue(4'd0, 32'h0000_0100, 32'h0000_0001, 8'd0, 1, "R1 add");
        issue(4'd5, 32'h0, 32'h0, 8'd0, 0, "R3 or zero");
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard: pending=%0d expected=0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule